// File: doc/BRIEF.md
# Bus Byte-Lane and Transfer-Width Sequencer

This block turns one CPU access request into the active-low byte-lane strobes that an external memory or I/O bus needs. It also turns it into the sequence of transfers that carries the access out. A request gives the two low address bits, an access size (byte, halfword, word or burst) and a mode bit that selects a 32-bit or a 16-bit data bus. On the 32-bit bus the four output pins are one enable per byte lane. On the 16-bit bus the same pins change meaning: the top pin carries address bit 1, the next one says whether the access is a byte or a halfword, and the lower two are the lane enables of the narrow bus.

A word access on the 16-bit bus is split into two transfers, and the top pin toggles from 0 to 1 between them. A burst runs four beats on the wide bus and eight on the narrow bus, and on the narrow bus the top pin alternates. The external bus logic pulses a beat-complete input to move the block to the next transfer. After the last one the pins return to the idle level and a one-cycle done pulse is raised. Accesses whose address is not aligned to their size are rejected with a one-cycle flag.

Top module: `bus_lane_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `lane_n` is 4'b1111 and `busy` is 0. Pin k of `lane_n` is the enable of data bits 8k+7:8k on the 32-bit bus.
- R2: In 32-bit mode (`req_narrow`=0), a byte access (`req_size`=0) at address A drives `lane_n` to 4'b1111 with only bit A cleared. That gives 1110, 1101, 1011 and 0111 for A = 0, 1, 2 and 3.
- R3: In 32-bit mode a halfword access (`req_size`=1) drives 1100 when A1=0 and 0011 when A1=1. A word access (`req_size`=2) drives 0000 in a single transfer.
- R4: In 16-bit mode (`req_narrow`=1), a byte access drives `lane_n[3]`=A1 and `lane_n[2]`=1. It also drives `lane_n[1:0]`=10 when A0=0 and 01 when A0=1.
- R5: In 16-bit mode a halfword access drives `lane_n[3]`=A1, `lane_n[2]`=0 and `lane_n[1:0]`=00.
- R6: In 16-bit mode a word access takes two transfers, `lane_n`=0000 and then 1000, which means A1 goes from 0 to 1 and the other pins stay low.
- R7: A burst (`req_size`=3) takes 4 transfers of 0000 in 32-bit mode. In 16-bit mode it takes 8 transfers, with `lane_n[3]` alternating 0,1,0,1... and the other pins low. A burst ignores the request address bits.
- R8: The pattern for a transfer appears in the cycle after the edge that accepts the request or the edge of the previous beat completion. It holds until an edge where `beat_done` is high.
- R9: At the edge where `beat_done` completes the last transfer, `lane_n` returns to 1111, `busy` falls, and `done` is high for exactly that one cycle.
- R10: A halfword request with A0=1, or a word request with A1:A0 not 00, is not started. `misalign` pulses for one cycle, and `lane_n` stays 1111 with `busy` low.
- R11: A request presented while `busy` is high is ignored: the pins, the transfer count and `misalign` are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_addr | input | 2 | Low address bits A1:A0 |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 burst |
| req_narrow | input | 1 | 1 selects the 16-bit bus, 0 the 32-bit bus |
| beat_done | input | 1 | Current transfer complete |
| lane_n | output | 4 | Lane enables (active low); in 16-bit mode {A1, byte-flag, enable hi, enable lo} |
| busy | output | 1 | A transfer sequence is in progress |
| done | output | 1 | One-cycle pulse after the last transfer |
| misalign | output | 1 | One-cycle pulse for a rejected unaligned request |

## Verification
A wrong beat count shows at the ports on the first beat completion that should end the sequence: `done` comes too early or too late, or `lane_n` fails to return to 1111. A stale address-bit state shows as the wrong A1 level on the very next narrow transfer. A wrong decode shows in the cycle right after acceptance, because the pins are registered exactly one edge after each event. Sweeping every size, address and mode, and checking every beat plus one held cycle for each, exposes each of these within a single access.

// File: rtl/blseq_pkg.sv
package blseq_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_BURST = 2'd3
  } xfer_size_e;

  typedef struct packed {
    xfer_size_e size;
    logic [1:0] addr;
    logic       narrow;
  } xfer_req_t;

  localparam logic [3:0] LANES_IDLE = 4'b1111;
endpackage

// File: rtl/blseq_decode.sv
module blseq_decode
  import blseq_pkg::*;
(
  input  xfer_req_t  req,
  input  logic       beat_odd,
  output logic [3:0] pins
);
  always_comb begin
    pins = LANES_IDLE;
    if (!req.narrow) begin
      unique case (req.size)
        SZ_BYTE: pins = LANES_IDLE ^ (4'd1 << req.addr);
        SZ_HALF: pins = req.addr[1] ? 4'b0011 : 4'b1100;
        default: pins = 4'b0000;
      endcase
    end else begin
      unique case (req.size)
        SZ_BYTE: pins = {req.addr[1], 1'b1, req.addr[0] ? 2'b01 : 2'b10};
        SZ_HALF: pins = {req.addr[1], 3'b000};
        default: pins = {beat_odd, 3'b000};
      endcase
    end
  end
endmodule

// File: rtl/blseq_ctrl.sv
module blseq_ctrl
  import blseq_pkg::*;
#(
  parameter int WIDE_BEATS   = 4,
  parameter int NARROW_BEATS = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  xfer_req_t req,
  input  logic      beat_done,
  output logic      busy,
  output logic      beat_odd,
  output logic      last,
  output logic      done
);
  localparam int MAXB = (NARROW_BEATS > WIDE_BEATS) ? NARROW_BEATS : WIDE_BEATS;
  localparam int CW   = (MAXB > 2) ? $clog2(MAXB) : 1;

  logic [CW-1:0] left_q, left_d;
  logic          odd_q, odd_d;
  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [CW-1:0] span;
  logic          adv;

  always_comb begin
    unique case (req.size)
      SZ_WORD:  span = req.narrow ? CW'(1) : CW'(0);
      SZ_BURST: span = req.narrow ? CW'(NARROW_BEATS - 1) : CW'(WIDE_BEATS - 1);
      default:  span = CW'(0);
    endcase
  end

  assign adv  = busy_q & beat_done;
  assign last = (left_q == CW'(0));

  always_comb begin
    left_d = left_q;
    odd_d  = odd_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start) begin
      left_d = span;
      odd_d  = 1'b0;
      busy_d = 1'b1;
    end else if (adv) begin
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        left_d = left_q - CW'(1);
        odd_d  = ~odd_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      odd_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      left_q <= left_d;
      odd_q  <= odd_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy     = busy_q;
  assign beat_odd = odd_q;
  assign done     = done_q;
endmodule

// File: rtl/bus_lane_seq.sv
module bus_lane_seq
  import blseq_pkg::*;
#(
  parameter int WIDE_BEATS   = 4,
  parameter int NARROW_BEATS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_addr,
  input  logic [1:0] req_size,
  input  logic       req_narrow,
  input  logic       beat_done,
  output logic [3:0] lane_n,
  output logic       busy,
  output logic       done,
  output logic       misalign
);
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  xfer_req_t  req_in, req_q, req_d;
  logic       bad_align, start, ctl_busy, ctl_odd, ctl_last, ctl_done;
  logic       mis_q, mis_d;
  logic [3:0] lane_q, lane_d, pins_new, pins_step;

  assign req_in = '{size: xfer_size_e'(req_size), addr: req_addr, narrow: req_narrow};

  always_comb begin
    unique case (req_in.size)
      SZ_HALF: bad_align = req_addr[0];
      SZ_WORD: bad_align = |req_addr;
      default: bad_align = 1'b0;
    endcase
  end

  assign start = req_valid & ~ctl_busy & ~bad_align;
  assign mis_d = req_valid & ~ctl_busy & bad_align;

  blseq_ctrl #(.WIDE_BEATS(WIDE_BEATS), .NARROW_BEATS(NARROW_BEATS)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .start(start), .req(req_in),
    .beat_done(beat_done), .busy(ctl_busy), .beat_odd(ctl_odd),
    .last(ctl_last), .done(ctl_done)
  );

  blseq_decode u_dec_new  (.req(req_in), .beat_odd(1'b0),     .pins(pins_new));
  blseq_decode u_dec_step (.req(req_q),  .beat_odd(~ctl_odd), .pins(pins_step));

  always_comb begin
    req_d  = start ? req_in : req_q;
    lane_d = lane_q;
    if (start)                      lane_d = pins_new;
    else if (ctl_busy && beat_done) lane_d = ctl_last ? LANES_IDLE : pins_step;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      req_q  <= '0;
      lane_q <= LANES_IDLE;
      mis_q  <= 1'b0;
    end else begin
      req_q  <= req_d;
      lane_q <= lane_d;
      mis_q  <= mis_d;
    end
  end

  assign lane_n   = lane_q;
  assign busy     = ctl_busy;
  assign done     = ctl_done;
  assign misalign = mis_q;
endmodule

// File: rtl/blseq_chk.sv
module blseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       beat_done,
  input logic [3:0] lane_n,
  input logic       busy,
  input logic       done,
  input logic       misalign
);
  // R1: idle means all lanes released
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> lane_n == 4'b1111);

  // R8: pattern held while no beat completes
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !beat_done |=> $stable(lane_n) && busy);

  // R9: done follows a completion while busy and ends the sequence
  a_r9_done_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy && $past(busy && beat_done));

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: misalign only after a request seen while idle, and nothing starts
  a_r10_reject: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> !busy && $past(req_valid && !busy));

  // R11: a request during a sequence never raises misalign
  a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    busy && req_valid |=> !misalign);

  // R2: any active transfer enables at least one lane
  a_r2_some_lane: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> lane_n != 4'b1111);
endmodule

bind bus_lane_seq blseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .beat_done(beat_done),
  .lane_n(lane_n), .busy(busy), .done(done), .misalign(misalign)
);

// File: tb/tb_bus_lane_seq.sv
`timescale 1ns/1ps
module tb_bus_lane_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_addr = 2'd0;
  logic [1:0] req_size = 2'd0;
  logic       req_narrow = 1'b0;
  logic       beat_done = 1'b0;
  logic [3:0] lane_n;
  logic       busy, done, misalign;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bus_lane_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_narrow(req_narrow), .beat_done(beat_done),
    .lane_n(lane_n), .busy(busy), .done(done), .misalign(misalign)
  );

  task automatic chk(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h (size %0d addr %0d narrow %0d)",
               tag, act, exp, req_size, req_addr, req_narrow);
    end
  endtask

  function automatic logic [3:0] exp_pins(int sz, int ad, int nar, int beat);
    if (nar == 0) begin
      if (sz == 0) return 4'hF ^ 4'(1 << ad);
      if (sz == 1) return (ad >= 2) ? 4'h3 : 4'hC;
      return 4'h0;
    end
    if (sz == 0) return 4'((ad / 2) * 8 + 4 + ((ad % 2) ? 1 : 2));
    if (sz == 1) return 4'((ad / 2) * 8);
    return 4'((beat % 2) * 8);
  endfunction

  function automatic int exp_beats(int sz, int nar);
    if (sz == 2) return nar ? 2 : 1;
    if (sz == 3) return nar ? 8 : 4;
    return 1;
  endfunction

  function automatic string tag_of(int sz, int nar);
    if (sz == 3) return "R7";
    if (nar == 0) return (sz == 0) ? "R2" : "R3";
    if (sz == 0) return "R4";
    if (sz == 1) return "R5";
    return "R6";
  endfunction

  task automatic run(input int sz, input int ad, input int nar);
    bit bad;
    int nb;
    logic [3:0] e;
    bad = (sz == 1 && (ad % 2) == 1) || (sz == 2 && ad != 0);
    nb  = exp_beats(sz, nar);
    @(negedge clk);
    req_valid = 1'b1; req_size = 2'(sz); req_addr = 2'(ad); req_narrow = nar[0];
    @(negedge clk);
    req_valid = 1'b0;
    if (bad) begin
      chk(misalign == 1'b1, "R10 misalign", {3'b0, misalign}, 4'h1);
      chk(busy == 1'b0 && lane_n == 4'hF, "R10 not started", lane_n, 4'hF);
      @(negedge clk);
      chk(misalign == 1'b0, "R10 pulse width", {3'b0, misalign}, 4'h0);
      return;
    end
    chk(misalign == 1'b0, "R10 no flag", {3'b0, misalign}, 4'h0);
    for (int b = 0; b < nb; b++) begin
      e = exp_pins(sz, ad, nar, b);
      chk(lane_n == e && busy, tag_of(sz, nar), lane_n, e);
      if (b == 0) begin
        req_valid = 1'b1; req_size = 2'd2; req_addr = 2'd3; req_narrow = ~nar[0];
      end
      @(negedge clk);
      if (b == 0) begin
        chk(misalign == 1'b0, "R11 no misalign", {3'b0, misalign}, 4'h0);
        req_valid = 1'b0; req_size = 2'(sz); req_addr = 2'(ad); req_narrow = nar[0];
      end
      chk(lane_n == e && busy, "R8 hold / R11 ignore", lane_n, e);
      beat_done = 1'b1;
      @(negedge clk);
      beat_done = 1'b0;
    end
    chk(lane_n == 4'hF && !busy, "R9 lanes idle", lane_n, 4'hF);
    chk(done == 1'b1, "R9 done", {3'b0, done}, 4'h1);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", {3'b0, done}, 4'h0);
    chk(lane_n == 4'hF, "R1 idle after", lane_n, 4'hF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(lane_n == 4'hF && !busy && !done && !misalign, "R1 reset state", lane_n, 4'hF);
    beat_done = 1'b1;
    @(negedge clk);
    beat_done = 1'b0;
    chk(lane_n == 4'hF && !done, "R1 idle beat ignored", lane_n, 4'hF);
    for (int nar = 0; nar < 2; nar++)
      for (int sz = 0; sz < 4; sz++)
        for (int ad = 0; ad < 4; ad++)
          run(sz, ad, nar);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule